// File: doc/BRIEF.md
# Bank-Switched Upper Memory Controller

This block sits on an 8-bit CPU bus with a 16-bit address and places a RAM expansion over the ROM window at pages 0xD0-0xFF. The RAM is split into two 4 KB banks that share pages 0xD0-0xDF and one common 8 KB region at pages 0xE0-0xFF. Soft switches in I/O page 0xC0 decide whether reads in the window come from RAM or ROM, whether writes reach RAM, and which of the two banks is visible in the lower 4 KB. Two status locations report the bank choice and the RAM-read choice in bit 7.

Writing is never turned on by a single access. A write-arming switch has to be read twice in a row before the write enable is set. A pre-write flag records the first read, and a write access to any arming switch clears that flag. The storage kept per page is set by the parameter `STORE_W` (log2 of bytes per page). At the default of 4, only the low four offset bits select a byte and the upper offset bits alias. Setting it to 8 gives the full 16 KB.

Read data is registered. It appears on `bus_rdata` in the cycle after the access and holds until the next read. The ROM lives outside the block and supplies `rom_data` for the current `bus_addr` within the same cycle.

Top module: `upper_mem_ctrl`

## Requirements
- R1: After reset, RAM read, write enable and pre-write are all 0 and bank 1 is selected. Reads at 0xD000-0xFFFF return `rom_data`, both status locations read 0x00, and `bus_rdata` is 0x00.
- R2: A switch access at 0xC080-0xC08F whose offset bit 0 is 0 clears write enable and pre-write. With offset bit 1 = 0 it selects RAM read; with offset bit 1 = 1 it selects ROM read.
- R3: Offsets with bit 0 = 1 are write-arming; they select RAM read when bit 1 = 1 and ROM read when bit 1 = 0. A read access to one of them copies pre-write into write enable and then sets pre-write. Two consecutive arming reads therefore enable writing, and a single one does not.
- R4: A write access to an arming switch leaves write enable unchanged and clears pre-write, so a following single arming read does not enable writing.
- R5: Every switch access sets the bank from offset bit 3: 0 selects bank 2 and 1 selects bank 1. Offset bit 2 is ignored, so 0xC084-0xC087 act like 0xC080-0xC083 and 0xC08C-0xC08F act like 0xC088-0xC08B.
- R6: A read of 0xC011 returns 0x80 when bank 2 is selected and 0x00 otherwise. A read of 0xC012 returns 0x80 when RAM read is on and 0x00 otherwise. Neither read changes any state.
- R7: Pages 0xD0-0xDF address the selected bank, and each bank keeps its own contents. Pages 0xE0-0xFF address one common region for both banks.
- R8: With RAM read off, reads at 0xD000-0xFFFF return `rom_data`. With write enable off, writes there leave RAM unchanged.
- R9: Reads of a switch return 0x00. Any other I/O-page offset returns 0x00 and changes no state.
- R10: Read data appears on `bus_rdata` in the cycle after the access and holds until the next read. A new switch state applies from the bus cycle after the switch access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 16 | Access address |
| bus_wdata | input | 8 | Write data |
| rom_data | input | 8 | ROM byte for the current `bus_addr` |
| bus_rdata | output | 8 | Registered read data |

## Verification
Every read result is due one cycle after its access. The bench records the access when the posedge takes it and compares the value at the next falling edge, which keeps the sample point away from any edge. Switch and status effects are due one cycle after the access, so each effect is seen through the next read and never in the same cycle. The arming tests place switch accesses in consecutive cycles to cover the back-to-back case. They also put a write access between reads to check that arming is cancelled.

// File: rtl/umc_pkg.sv
// Package: constants and the switch state type shared by the
// upper memory controller and its checker.
package umc_pkg;

    localparam logic [7:0] IO_PAGE   = 8'hC0;  // soft-switch / status page
    localparam logic [3:0] SW_NIBBLE = 4'h8;   // switches at offsets 0x80-0x8F
    localparam logic [7:0] STAT_BANK = 8'h11;  // bank-2 status offset
    localparam logic [7:0] STAT_RAM  = 8'h12;  // RAM-read status offset

    // Mapping state held by the switch logic.
    typedef struct packed {
        logic rd_ram;   // reads in window come from RAM
        logic wr_en;    // writes in window reach RAM
        logic pre_wr;   // first arming read seen
        logic bank2;    // bank 2 visible at 0xD0-0xDF
    } sw_state_t;

endpackage

// File: rtl/umc_switches.sv
// Module: soft-switch state machine.
// Holds the read source, write enable, pre-write flag and bank select.
// Assumes: hit is one cycle wide per access; sel is offset bits [3:0].
module umc_switches
    import umc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      is_read,
    input  logic [3:0] sel,
    output sw_state_t st
);

    // Update the mapping state on each switch access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (hit) begin
            st.bank2 <= !sel[3];
            if (!sel[0]) begin
                st.rd_ram <= !sel[1];
                st.wr_en  <= 1'b0;
                st.pre_wr <= 1'b0;
            end else begin
                st.rd_ram <= sel[1];
                if (is_read) begin
                    st.wr_en <= st.pre_wr;
                end
                st.pre_wr <= is_read;
            end
        end
    end

endmodule

// File: rtl/umc_ram.sv
// Module: single-port-write, combinational-read byte array.
// Assumes: one write per cycle; no reset of contents.
module umc_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store a byte when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Read the addressed byte.
    always_comb rdata = mem[addr];

endmodule

// File: rtl/upper_mem_ctrl.sv
// Module: upper memory controller top.
// Decodes the bus into the switch page, the banked pages and the common
// pages. Steers writes to the enabled RAM and registers read data.
// Assumes: rom_data is valid for bus_addr in the access cycle.
module upper_mem_ctrl
    import umc_pkg::*;
#(
    parameter int STORE_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_we,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic [7:0]  rom_data,
    output logic [7:0]  bus_rdata
);

    localparam int BANK_AW  = 4 + STORE_W;  // 16 pages per bank
    localparam int COM_AW   = 5 + STORE_W;  // 32 common pages
    localparam int NUM_BANK = 2;

    logic [7:0] page, offs;
    logic       in_io, in_bank, in_com, sw_hit;
    sw_state_t  st;
    logic       st_rd, st_wen, st_pre, st_bank2;

    logic [BANK_AW-1:0] bank_addr;
    logic [COM_AW-1:0]  com_addr;
    logic [7:0]         bank_q [NUM_BANK];
    logic [7:0]         com_q;
    logic               wr_ok;
    logic [7:0]         rd_next;

    // Split the address and classify the access.
    always_comb begin
        page    = bus_addr[15:8];
        offs    = bus_addr[7:0];
        in_io   = (page == IO_PAGE);
        in_bank = (page[7:4] == 4'hD);
        in_com  = (page[7:5] == 3'b111);
        sw_hit  = bus_valid && in_io && (offs[7:4] == SW_NIBBLE);
        wr_ok   = bus_valid && bus_we && st.wr_en;
    end

    assign bank_addr = {page[3:0], offs[STORE_W-1:0]};
    assign com_addr  = {page[4:0], offs[STORE_W-1:0]};

    assign st_rd    = st.rd_ram;
    assign st_wen   = st.wr_en;
    assign st_pre   = st.pre_wr;
    assign st_bank2 = st.bank2;

    umc_switches i_switches (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (sw_hit),
        .is_read (!bus_we),
        .sel     (offs[3:0]),
        .st      (st)
    );

    // One array per switchable bank; index 0 is bank 1, index 1 is bank 2.
    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        umc_ram #(.AW(BANK_AW), .DW(8)) i_bank (
            .clk   (clk),
            .we    (wr_ok && in_bank && (st.bank2 == (b == 1))),
            .addr  (bank_addr),
            .wdata (bus_wdata),
            .rdata (bank_q[b])
        );
    end

    umc_ram #(.AW(COM_AW), .DW(8)) i_common (
        .clk   (clk),
        .we    (wr_ok && in_com),
        .addr  (com_addr),
        .wdata (bus_wdata),
        .rdata (com_q)
    );

    // Select the byte a read of the current address returns.
    always_comb begin
        rd_next = 8'h00;
        if (in_io) begin
            if (offs == STAT_BANK) rd_next = {st.bank2, 7'b0};
            else if (offs == STAT_RAM) rd_next = {st.rd_ram, 7'b0};
        end else if (in_bank || in_com) begin
            if (!st.rd_ram) rd_next = rom_data;
            else if (in_bank) rd_next = st.bank2 ? bank_q[1] : bank_q[0];
            else rd_next = com_q;
        end
    end

    // Register read data; hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 8'h00;
        end else if (bus_valid && !bus_we) begin
            bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/umc_checker.sv
// Module: property checker for upper_mem_ctrl, attached with bind.
// Assumes: state bits are brought out by the top as plain signals.
module umc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_we,
    input logic [15:0] bus_addr,
    input logic [7:0]  rom_data,
    input logic [7:0]  bus_rdata,
    input logic        st_rd,
    input logic        st_wen,
    input logic        st_pre,
    input logic        st_bank2
);

    logic sw_acc, stat_acc, win;
    assign sw_acc   = bus_valid && (bus_addr[15:4] == 12'hC08);
    assign stat_acc = bus_valid && !bus_we &&
                      ((bus_addr == 16'hC011) || (bus_addr == 16'hC012));
    assign win      = (bus_addr[15:12] == 4'hD) || (bus_addr[15:13] == 3'b111);

    AST_ENABLE_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_wen) |-> $past(st_pre));                                  // R3

    AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_acc && bus_we) |=> !st_pre);                                   // R4

    AST_WRITE_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_acc && bus_we && bus_addr[0]) |=> $stable(st_wen));            // R4

    AST_PLAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_acc && !bus_addr[0]) |=> (!st_wen && !st_pre));                // R2

    AST_BANK_FROM_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_acc |=> (st_bank2 == !$past(bus_addr[3])));                     // R5

    AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stat_acc |=> $stable({st_rd, st_wen, st_pre, st_bank2}));          // R6

    AST_ROM_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && win && !st_rd) |=> (bus_rdata == $past(rom_data))); // R8

endmodule

bind upper_mem_ctrl umc_checker i_umc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .rom_data  (rom_data),
    .bus_rdata (bus_rdata),
    .st_rd     (st_rd),
    .st_wen    (st_wen),
    .st_pre    (st_pre),
    .st_bank2  (st_bank2)
);

// File: tb/test_upper_mem_ctrl.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares
// bus_rdata one cycle after each read access.
module test_upper_mem_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  rom_data;
    logic [7:0]  bus_rdata;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    function automatic logic [7:0] rom_of(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'h5A;
    endfunction

    assign rom_data = rom_of(bus_addr);

    upper_mem_ctrl i_upper_mem_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rom_data  (rom_data),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0; bus_valid = 1'b1;
        sb.push_back('{e, tag});
        @(posedge clk);
        #1 bus_valid = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d; bus_valid = 1'b1;
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    // Monitor: each read taken at a posedge is compared at the next negedge.
    initial begin
        forever begin
            bit issued;
            item_t it;
            @(posedge clk);
            issued = bus_valid && !bus_we && rst_n;
            @(negedge clk);
            if (issued) begin
                if (sb.size() == 0) begin
                    check(bus_rdata, 8'hxx, "scoreboard empty");
                end else begin
                    it = sb.pop_front();
                    check(bus_rdata, it.exp, it.tag);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bus_rdata, 8'h00, "R1 rdata in reset");
        rst_n = 1'b1;

        // R1: reset mapping reads ROM, status clear
        rd(16'hD003, rom_of(16'hD003), "R1 bank page from ROM");
        rd(16'hE004, rom_of(16'hE004), "R1 common page from ROM");
        rd(16'hC011, 8'h00, "R1 bank status");
        rd(16'hC012, 8'h00, "R1 ram status");
        wr(16'hD003, 8'h11);

        // R3: two back-to-back arming reads, RAM read bank 1
        rd(16'hC08B, 8'h00, "R9 switch reads zero");
        rd(16'hC08B, 8'h00, "R9 switch reads zero");
        rd(16'hC012, 8'h80, "R6 ram status on");
        rd(16'hC011, 8'h00, "R6 bank1 status");
        wr(16'hD003, 8'h22);
        wr(16'hE004, 8'h33);
        rd(16'hD003, 8'h22, "R3 write enabled bank1");
        rd(16'hE004, 8'h33, "R7 common write");

        // R2: plain RAM-read switch disables writes
        rd(16'hC088, 8'h00, "R9 switch reads zero");
        wr(16'hD003, 8'hAA);
        rd(16'hD003, 8'h22, "R2 write disabled");

        // R3: a single arming read is not enough
        rd(16'hC08B, 8'h00, "R9 switch reads zero");
        wr(16'hD003, 8'h11);
        rd(16'hD003, 8'h22, "R3 single arm no write");
        rd(16'hC08B, 8'h00, "R9 switch reads zero");
        wr(16'hD003, 8'h55);
        rd(16'hD003, 8'h55, "R3 second arm enables");

        // R4: write access keeps enable but disarms
        wr(16'hC08B, 8'h00);
        wr(16'hD003, 8'h56);
        rd(16'hD003, 8'h56, "R4 enable kept on switch write");
        rd(16'hC08B, 8'h00, "R9 switch reads zero");
        wr(16'hD003, 8'h57);
        rd(16'hD003, 8'h56, "R4 disarmed by write");

        // R5/R7: bank 2 separate, common shared
        rd(16'hC083, 8'h00, "R9 switch reads zero");
        rd(16'hC083, 8'h00, "R9 switch reads zero");
        rd(16'hC011, 8'h80, "R5 bank2 selected");
        wr(16'hD003, 8'h66);
        wr(16'hE004, 8'h77);
        rd(16'hD003, 8'h66, "R7 bank2 data");
        rd(16'hC08B, 8'h00, "R9 switch reads zero");
        rd(16'hC08B, 8'h00, "R9 switch reads zero");
        rd(16'hD003, 8'h56, "R7 bank1 kept");
        rd(16'hE004, 8'h77, "R7 common shared");

        // R5/R8: mirrors and ROM fallback
        rd(16'hC084, 8'h00, "R9 switch reads zero");
        rd(16'hC011, 8'h80, "R5 mirror bank2");
        rd(16'hD003, 8'h66, "R5 mirror RAM read");
        wr(16'hD003, 8'h99);
        rd(16'hD003, 8'h66, "R8 write ignored");
        rd(16'hC08E, 8'h00, "R9 switch reads zero");
        rd(16'hC011, 8'h00, "R5 mirror bank1");
        rd(16'hC012, 8'h00, "R2 ROM read status");
        rd(16'hD003, rom_of(16'hD003), "R8 ROM bank page");
        rd(16'hE004, rom_of(16'hE004), "R8 ROM common page");

        // R9: other I/O offsets are inert
        rd(16'hC030, 8'h00, "R9 other offset");
        rd(16'hC0A0, 8'h00, "R9 other offset");
        rd(16'hC012, 8'h00, "R9 state unchanged");
        rd(16'hC08C, 8'h00, "R9 switch reads zero");
        rd(16'hD003, 8'h56, "R5 mirror of bank1 RAM read");
        rd(16'hC08A, 8'h00, "R9 switch reads zero");
        rd(16'hC012, 8'h00, "R2 ROM selected");

        // R10: data holds between reads
        rd(16'hC011, 8'h00, "R6 status");
        rd(16'hE004, rom_of(16'hE004), "R10 latest read");
        repeat (3) @(negedge clk);
        check(bus_rdata, rom_of(16'hE004), "R10 data held");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule